// File: doc/BRIEF.md
# Banked Video Memory Host Port

This block is the host-facing slave of a display controller. A host issues 16-bit word accesses with a byte address, a size in bytes and separate read and write strobes. The block turns each legal access into a request on a synchronous video RAM port. It also flags illegal accesses. The RAM holds two banks of 64K words. The host sees a 64K-word window onto the bank that is currently latched.

A relocatable window of 16 words overlays the host window. Those 16 words are the controller's control registers, and they are stored in the lowest 16 words of RAM. Word addresses inside the overlay reach those registers whichever bank is selected.

A single write-only port address loads a 16-entry palette. Each write to it stores into the next entry in turn. The video side reads the palette through a separate index and colour pair.

The bank number and the overlay offset are sampled on a one-cycle latch strobe, normally given at a frame boundary. The strobe is the only way either value changes.

Top module: `vram_host_port`

## Requirements
- R1: An access is legal only if all of these hold: `host_size` equals 2 (the value is a byte count), `host_addr[0]` is 0, and the two strobes are not both high. An illegal access raises `host_err` for exactly the following cycle, issues no RAM request and does not change the palette.
- R2: The word address is `host_addr >> 1`. A read or write to any word address of 0x10000 or above is an error and has no effect, except a write to the palette word in R6.
- R3: When the latched bank is 2 or greater, every access is an error and has no effect, including palette writes.
- R4: A word address w with off ≤ w ≤ off+15, where off is the latched overlay offset, maps to RAM word w−off. This mapping applies to any legal bank and takes priority over the bank mapping.
- R5: Every other legal word address w maps to RAM word bank·0x10000 + w. Writes reach that word, and reads return it.
- R6: A write to word address 0x40000 (byte 0x80000) stores `host_wdata` into the palette entry at the current index, and the index then advances modulo 16. The write issues no RAM request. `pal_color` shows the entry selected by `pal_idx` in the same cycle.
- R7: A read of the palette word is an error and returns zero.
- R8: After reset the overlay offset is 0x200, the bank is 0, the palette index and every palette entry are 0, and `host_err` is low.
- R9: Read data appears on `host_rdata` in the cycle after the read strobe. In the same cycle `host_err` is valid. `host_rdata` is zero whenever `host_err` is high.
- R10: `cfg_bank` and `cfg_regoff` take effect only from the cycle after a cycle in which `cfg_latch` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 20 | Host byte address |
| host_size | input | 3 | Access size in bytes |
| host_rd | input | 1 | Read strobe |
| host_wr | input | 1 | Write strobe |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data, one cycle after the strobe |
| host_err | output | 1 | Access error, one cycle after the strobe |
| cfg_latch | input | 1 | Sample bank and overlay offset |
| cfg_bank | input | 2 | Bank number to latch |
| cfg_regoff | input | 16 | Overlay word offset to latch |
| mem_en | output | 1 | RAM request |
| mem_we | output | 1 | RAM write enable |
| mem_addr | output | 17 | RAM word address |
| mem_wdata | output | 16 | RAM write data |
| mem_rdata | input | 16 | RAM read data, one cycle after the request |
| pal_idx | input | 4 | Palette entry to show |
| pal_color | output | 16 | Selected palette entry |

## Verification
The address mapping is exercised with writes followed by read-back at these points:
- plain window words;
- the first and last word of the overlay;
- the words just below and just above the overlay;
- the highest legal word.

Together these separate overlay hits from ordinary bank hits. A second overlay offset combined with bank 1 shows that the overlay wins over the bank. The same test shows that the word under the old overlay becomes ordinary memory.

Illegal patterns are each followed by a read-back of the word they could have touched. These patterns are odd addresses, the wrong sizes, both strobes high, out-of-window words, palette reads and banks 2 and 3. The palette is loaded with seventeen writes, so the wrap of the index shows as an overwritten entry 0.

// File: rtl/vram_host_port_pkg.sv
package vram_host_port_pkg;

    localparam int ACC_BYTES = 2;

    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_MEM  = 2'd1,
        ACC_PAL  = 2'd2,
        ACC_BAD  = 2'd3
    } acc_kind_e;

endpackage

// File: rtl/vhp_decode.sv
module vhp_decode
    import vram_host_port_pkg::*;
#(
    parameter int BA_W      = 20,
    parameter int MA_W      = 17,
    parameter int OFF_W     = 16,
    parameter int BK_W      = 2,
    parameter int NUM_BANKS = 2,
    parameter int WIN_WORDS = 65536,
    parameter int REG_WORDS = 16,
    parameter int PAL_WORD  = 32'h40000
) (
    input  logic [BA_W-1:0]  addr,
    input  logic [2:0]       size,
    input  logic             rd,
    input  logic             wr,
    input  logic [BK_W-1:0]  bank,
    input  logic [OFF_W-1:0] regoff,
    output acc_kind_e        kind,
    output logic [MA_W-1:0]  mem_addr,
    output logic             reg_hit
);
    localparam int WD_W = BA_W - 1;
    localparam int CW   = (WD_W > OFF_W ? WD_W : OFF_W) + 1;

    logic [WD_W-1:0] word;
    logic [CW-1:0]   word_x;
    logic [CW-1:0]   rel;
    logic            legal;
    logic            is_pal;
    logic            in_win;

    always_comb begin
        word    = addr[BA_W-1:1];
        word_x  = CW'(word);
        rel     = word_x - CW'(regoff);
        legal   = (32'(size) == ACC_BYTES) && !addr[0] && !(rd && wr)
                  && (32'(bank) < NUM_BANKS);
        is_pal  = (32'(word) == PAL_WORD);
        in_win  = (32'(word) < WIN_WORDS);
        reg_hit = (word_x >= CW'(regoff)) && (rel < CW'(REG_WORDS));

        if (!(rd || wr))          kind = ACC_NONE;
        else if (!legal)          kind = ACC_BAD;
        else if (wr && is_pal)    kind = ACC_PAL;
        else if (!in_win)         kind = ACC_BAD;
        else                      kind = ACC_MEM;

        if (reg_hit) mem_addr = MA_W'(rel);
        else         mem_addr = MA_W'(32'(bank) * WIN_WORDS + 32'(word));
    end
endmodule

// File: rtl/vhp_palette.sv
module vhp_palette #(
    parameter int ENTRIES = 16,
    parameter int DW      = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [DW-1:0]              wdata,
    input  logic [$clog2(ENTRIES)-1:0] rd_idx,
    output logic [DW-1:0]              rd_color
);
    localparam int IW = $clog2(ENTRIES);

    typedef struct packed {
        logic [IW-1:0]             idx;
        logic [ENTRIES-1:0][DW-1:0] tab;
    } pal_state_t;

    pal_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.tab[st_q.idx] = wdata;
            if (st_q.idx == IW'(ENTRIES - 1)) st_d.idx = '0;
            else                               st_d.idx = st_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_color = st_q.tab[rd_idx];

    AST_PAL_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && (st_q.idx == IW'(ENTRIES - 1)) |=> (st_q.idx == '0)); // R6

    AST_PAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(st_q.idx)); // R6
endmodule

// File: rtl/vram_host_port.sv
module vram_host_port
    import vram_host_port_pkg::*;
#(
    parameter int DW          = 16,
    parameter int NUM_BANKS   = 2,
    parameter int WIN_WORDS   = 65536,
    parameter int REG_WORDS   = 16,
    parameter int PAL_ENTRIES = 16,
    parameter int PAL_WORD    = 32'h40000,
    parameter int OFF_W       = 16,
    parameter int BK_W        = 2,
    parameter int REG_RESET   = 32'h200,
    parameter int BA_W        = $clog2(PAL_WORD + 1) + 1,
    parameter int MA_W        = $clog2(NUM_BANKS * WIN_WORDS),
    parameter int PI_W        = $clog2(PAL_ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BA_W-1:0]  host_addr,
    input  logic [2:0]       host_size,
    input  logic             host_rd,
    input  logic             host_wr,
    input  logic [DW-1:0]    host_wdata,
    output logic [DW-1:0]    host_rdata,
    output logic             host_err,
    input  logic             cfg_latch,
    input  logic [BK_W-1:0]  cfg_bank,
    input  logic [OFF_W-1:0] cfg_regoff,
    output logic             mem_en,
    output logic             mem_we,
    output logic [MA_W-1:0]  mem_addr,
    output logic [DW-1:0]    mem_wdata,
    input  logic [DW-1:0]    mem_rdata,
    input  logic [PI_W-1:0]  pal_idx,
    output logic [DW-1:0]    pal_color
);
    typedef struct packed {
        logic [BK_W-1:0]  bank;
        logic [OFF_W-1:0] regoff;
        logic             err;
        logic             rd_pend;
    } port_state_t;

    localparam port_state_t STATE_RESET = '{
        bank:    '0,
        regoff:  OFF_W'(REG_RESET),
        err:     1'b0,
        rd_pend: 1'b0
    };

    port_state_t st_d, st_q;
    acc_kind_e   kind;
    logic        dec_reg_hit;
    logic        pal_wr;

    vhp_decode #(
        .BA_W(BA_W), .MA_W(MA_W), .OFF_W(OFF_W), .BK_W(BK_W),
        .NUM_BANKS(NUM_BANKS), .WIN_WORDS(WIN_WORDS),
        .REG_WORDS(REG_WORDS), .PAL_WORD(PAL_WORD)
    ) u_decode (
        .addr(host_addr), .size(host_size), .rd(host_rd), .wr(host_wr),
        .bank(st_q.bank), .regoff(st_q.regoff),
        .kind(kind), .mem_addr(mem_addr), .reg_hit(dec_reg_hit)
    );

    vhp_palette #(.ENTRIES(PAL_ENTRIES), .DW(DW)) u_palette (
        .clk(clk), .rst_n(rst_n), .wr_en(pal_wr), .wdata(host_wdata),
        .rd_idx(pal_idx), .rd_color(pal_color)
    );

    always_comb begin
        st_d         = st_q;
        st_d.err     = (kind == ACC_BAD);
        st_d.rd_pend = (kind == ACC_MEM) && host_rd;
        if (cfg_latch) begin
            st_d.bank   = cfg_bank;
            st_d.regoff = cfg_regoff;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= STATE_RESET;
        else        st_q <= st_d;
    end

    assign mem_en     = (kind == ACC_MEM);
    assign mem_we     = host_wr;
    assign mem_wdata  = host_wdata;
    assign pal_wr     = (kind == ACC_PAL);
    assign host_err   = st_q.err;
    assign host_rdata = st_q.rd_pend ? mem_rdata : '0;

    AST_MEM_THEN_OK: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |=> !host_err); // R1

    AST_ERR_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        host_err |-> $past(host_rd || host_wr)); // R9

    AST_ERR_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        host_err |-> (host_rdata == '0)); // R9

    AST_REG_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en && dec_reg_hit |-> (32'(mem_addr) < REG_WORDS)); // R4

    AST_BANK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en || pal_wr) |-> (32'(st_q.bank) < NUM_BANKS)); // R3
endmodule

// File: tb/vram_host_port_tb_top.sv
`timescale 1ns/1ps
module vram_host_port_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] host_addr = '0;
    logic [2:0]  host_size = 3'd2;
    logic        host_rd = 1'b0;
    logic        host_wr = 1'b0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        host_err;
    logic        cfg_latch = 1'b0;
    logic [1:0]  cfg_bank = '0;
    logic [15:0] cfg_regoff = 16'h0200;
    logic        mem_en, mem_we;
    logic [16:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic [3:0]  pal_idx = '0;
    logic [15:0] pal_color;

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] ram [int];

    always #2 clk = ~clk;

    vram_host_port dut_i (.*);

    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) ram[int'(mem_addr)] = mem_wdata;
            else mem_rdata <= ram.exists(int'(mem_addr)) ? ram[int'(mem_addr)] : 16'h0;
        end
    end

    typedef struct packed {
        logic        rd;
        logic        wr;
        logic [19:0] addr;
        logic [2:0]  size;
        logic [15:0] wdata;
        logic        err;
        logic [15:0] rdata;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b1, 20'h00020, 3'd2, 16'h1111, 1'b0, 16'h0000}, // R5
        '{1'b1, 1'b0, 20'h00020, 3'd2, 16'h0000, 1'b0, 16'h1111}, // R5
        '{1'b0, 1'b1, 20'h00400, 3'd2, 16'hAAAA, 1'b0, 16'h0000}, // R4 R8
        '{1'b1, 1'b0, 20'h00000, 3'd2, 16'h0000, 1'b0, 16'hAAAA}, // R4
        '{1'b0, 1'b1, 20'h0041E, 3'd2, 16'hBBBB, 1'b0, 16'h0000}, // R4
        '{1'b1, 1'b0, 20'h0001E, 3'd2, 16'h0000, 1'b0, 16'hBBBB}, // R4
        '{1'b0, 1'b1, 20'h00420, 3'd2, 16'hCCCC, 1'b0, 16'h0000}, // R5
        '{1'b1, 1'b0, 20'h00420, 3'd2, 16'h0000, 1'b0, 16'hCCCC}, // R5
        '{1'b1, 1'b0, 20'h003FE, 3'd2, 16'h0000, 1'b0, 16'h0000}, // R5
        '{1'b1, 1'b0, 20'h00021, 3'd2, 16'h0000, 1'b1, 16'h0000}, // R1
        '{1'b1, 1'b0, 20'h00020, 3'd4, 16'h0000, 1'b1, 16'h0000}, // R1
        '{1'b1, 1'b0, 20'h00020, 3'd1, 16'h0000, 1'b1, 16'h0000}, // R1
        '{1'b0, 1'b1, 20'h00020, 3'd1, 16'hDEAD, 1'b1, 16'h0000}, // R1
        '{1'b1, 1'b0, 20'h00020, 3'd2, 16'h0000, 1'b0, 16'h1111}, // R1
        '{1'b0, 1'b1, 20'h20000, 3'd2, 16'hEEEE, 1'b1, 16'h0000}, // R2
        '{1'b1, 1'b0, 20'h00000, 3'd2, 16'h0000, 1'b0, 16'hAAAA}, // R2
        '{1'b1, 1'b0, 20'h80000, 3'd2, 16'h0000, 1'b1, 16'h0000}, // R7
        '{1'b1, 1'b0, 20'h1FFFE, 3'd2, 16'h0000, 1'b0, 16'h0000}  // R2
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic acc(input string req, input logic rd, input logic wr,
                       input logic [19:0] addr, input logic [2:0] size,
                       input logic [15:0] wdata, input logic exp_err,
                       input logic [15:0] exp_rdata);
        @(negedge clk);
        host_rd = rd; host_wr = wr; host_addr = addr;
        host_size = size; host_wdata = wdata;
        @(negedge clk);
        host_rd = 1'b0; host_wr = 1'b0;
        check({req, " err"}, 32'(host_err), 32'(exp_err));
        if (rd || exp_err) check({req, " rdata"}, 32'(host_rdata), 32'(exp_rdata));
    endtask

    task automatic latch(input logic [1:0] b, input logic [15:0] off);
        @(negedge clk);
        cfg_bank = b; cfg_regoff = off; cfg_latch = 1'b1;
        @(negedge clk);
        cfg_latch = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 err after reset", 32'(host_err), 0);
        check("R8 rdata after reset", 32'(host_rdata), 0);
        check("R8 palette entry 0", 32'(pal_color), 0);

        for (int i = 0; i < NV; i++)
            acc($sformatf("vec%0d", i), VECS[i].rd, VECS[i].wr, VECS[i].addr,
                VECS[i].size, VECS[i].wdata, VECS[i].err, VECS[i].rdata);

        acc("R1 both strobes", 1'b1, 1'b1, 20'h00020, 3'd2, 16'h5555, 1'b1, 16'h0);
        acc("R1 both strobes no write", 1'b1, 1'b0, 20'h00020, 3'd2, 16'h0, 1'b0, 16'h1111);

        for (int i = 0; i < 17; i++)
            acc("R6 palette write", 1'b0, 1'b1, 20'h80000, 3'd2, 16'(16'h0100 + i), 1'b0, 16'h0);
        for (int k = 0; k < 16; k++) begin
            pal_idx = 4'(k);
            #1;
            check($sformatf("R6 palette entry %0d", k), 32'(pal_color),
                  (k == 0) ? 32'h0110 : 32'(16'h0100 + k));
        end
        acc("R6 palette write leaves RAM", 1'b1, 1'b0, 20'h00000, 3'd2, 16'h0, 1'b0, 16'hAAAA);

        @(negedge clk);
        cfg_bank = 2'd1; cfg_regoff = 16'h0300;
        acc("R10 no latch keeps bank", 1'b1, 1'b0, 20'h00020, 3'd2, 16'h0, 1'b0, 16'h1111);
        latch(2'd1, 16'h0300);
        acc("R5 bank1 write", 1'b0, 1'b1, 20'h00020, 3'd2, 16'h2222, 1'b0, 16'h0);
        acc("R5 bank1 read", 1'b1, 1'b0, 20'h00020, 3'd2, 16'h0, 1'b0, 16'h2222);
        acc("R4 overlay over bank1", 1'b1, 1'b0, 20'h00600, 3'd2, 16'h0, 1'b0, 16'hAAAA);
        acc("R10 old overlay now ram", 1'b1, 1'b0, 20'h00400, 3'd2, 16'h0, 1'b0, 16'h0000);
        latch(2'd0, 16'h0200);
        acc("R5 bank0 separate", 1'b1, 1'b0, 20'h00020, 3'd2, 16'h0, 1'b0, 16'h1111);
        latch(2'd2, 16'h0200);
        acc("R3 bank2 read", 1'b1, 1'b0, 20'h00020, 3'd2, 16'h0, 1'b1, 16'h0);
        acc("R3 bank2 palette write", 1'b0, 1'b1, 20'h80000, 3'd2, 16'h7777, 1'b1, 16'h0);
        pal_idx = 4'd1;
        #1;
        check("R3 palette untouched", 32'(pal_color), 32'h0101);
        latch(2'd3, 16'h0200);
        acc("R3 bank3 write", 1'b0, 1'b1, 20'h00020, 3'd2, 16'h9999, 1'b1, 16'h0);
        latch(2'd0, 16'h0200);
        acc("R3 bank3 write ignored", 1'b1, 1'b0, 20'h00020, 3'd2, 16'h0, 1'b0, 16'h1111);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule